// File: doc/BRIEF.md
# Palette Lookup and Overlay-Video Blender

This block merges one bitmap overlay pixel onto one video pixel per clock. The overlay pixel arrives as a palette index of 1, 2, 4 or 8 significant bits. The index is resolved to a YCbCr colour, either through a 256-entry colour table that the host writes, or through a fixed table computed in logic. The resolved colour is then mixed with the time-aligned video pixel under a 3-bit blend code. A per-window transparency key can make a matching index invisible so the video shows through.

Two overlay windows are configured independently: bit depth, table choice, blend code, key enable and key index. Each incoming pixel carries the number of the window it belongs to. The blended YCbCr pixel leaves the block a fixed two cycles after it enters.

Top module: `osd_pixel_blender`

## Requirements
- R1: While reset is held and on the first cycle after it, `out_valid` is 0 and `out_y`, `out_cb` and `out_cr` are all 0.
- R2: `out_valid` rises exactly two clock cycles after `in_valid`, for every pixel, including back-to-back pixels and pixels separated by gaps.
- R3: The window depth code selects the number of significant index bits: 0 selects 1 bit, 1 selects 2 bits, 2 selects 4 bits and 3 selects 8 bits. Index bits above that width are ignored for both the lookup and the key compare.
- R4: A strobe on `pal_ycb_we` holds Y from bits [15:8] and Cb from bits [7:0]. A strobe on `pal_cr_we` writes the writable table entry addressed by bits [7:0], using Cr from bits [15:8] and the held Y and Cb. If both strobes occur in the same cycle, the entry takes the Y and Cb held before that cycle.
- R5: A pixel that reads an entry in the same cycle as that entry is written sees the old contents. A pixel one cycle later sees the new contents.
- R6: A window whose fixed-table bit is 1 resolves index i to Y = i, Cb = bitwise NOT of i, and Cr = i with its two nibbles swapped.
- R7: Blend codes 0 to 6 give each output component the value (o*c + v*(8-c) + 4) >> 3, where o is the overlay component, v is the video component and c is the code.
- R8: Blend code 7 outputs the overlay colour unchanged.
- R9: Blend code 0 outputs the video pixel unchanged.
- R10: When a window's key enable is 1 and its masked index equals its key index masked to the same width, the output is the video pixel. When key enable is 0, the key has no effect.
- R11: Each pixel uses only the configuration of the window named by `in_win`. Pixels from different windows may alternate on consecutive cycles.
- R12: After reset, every writable table entry reads as Y = Cb = Cr = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pal_ycb_we | input | 1 | Strobe to hold the Y and Cb half of a table entry |
| pal_ycb_data | input | 16 | Y in [15:8], Cb in [7:0] |
| pal_cr_we | input | 1 | Strobe to commit a table entry |
| pal_cr_data | input | 16 | Cr in [15:8], entry address in [7:0] |
| cfg_depth | input | 2*NUM_WIN | Per-window depth code, window n in bits [2n+1:2n] |
| cfg_fixed | input | NUM_WIN | Per-window table select: 1 selects the fixed table |
| cfg_blend | input | 3*NUM_WIN | Per-window blend code, window n in bits [3n+2:3n] |
| cfg_key_en | input | NUM_WIN | Per-window transparency key enable |
| cfg_key | input | 8*NUM_WIN | Per-window transparent index, window n in bits [8n+7:8n] |
| in_valid | input | 1 | Input pixel pair valid |
| in_win | input | WIN_W | Window number of the overlay pixel |
| in_idx | input | 8 | Overlay palette index |
| in_y | input | 8 | Video Y |
| in_cb | input | 8 | Video Cb |
| in_cr | input | 8 | Video Cr |
| out_valid | output | 1 | Output pixel valid |
| out_y | output | 8 | Blended Y |
| out_cb | output | 8 | Blended Cb |
| out_cr | output | 8 | Blended Cr |

## Verification
The hardest case to reach is a table write and a pixel lookup that land on the same entry in the same cycle. There the answer depends on the order of the read and the write inside one edge. The stimulus commits a new value to an entry while a pixel reads that entry, then reads it again one cycle later, so both sides of the boundary are checked. Key matching on masked indices is also reached on purpose: an index carries nonzero bits above the window's depth, and the key has the same low bits but different high bits, so a compare on the full width would miss.

// File: rtl/osd_blend_pkg.sv
// Package: shared constants and helper functions for the overlay blender.
// Assumes 8-bit YCbCr components and 8-bit palette indices.
package osd_blend_pkg;

    localparam int COMP_W  = 8;
    localparam int IDX_W   = 8;
    localparam int CODE_W  = 3;
    localparam int DEPTH_W = 2;
    localparam int WT_W    = 4;
    localparam int NCOMP   = 3;
    localparam int ENTRY_W = NCOMP * COMP_W;

    // component order inside a packed colour: [2]=Y, [1]=Cb, [0]=Cr
    typedef logic [NCOMP-1:0][COMP_W-1:0] ycc_t;

    typedef enum logic [DEPTH_W-1:0] {
        BITS_1 = 2'd0,
        BITS_2 = 2'd1,
        BITS_4 = 2'd2,
        BITS_8 = 2'd3
    } depth_e;

    // mask of significant index bits for a depth code
    function automatic logic [IDX_W-1:0] index_mask(input logic [DEPTH_W-1:0] d);
        case (depth_e'(d))
            BITS_1:  return IDX_W'(8'h01);
            BITS_2:  return IDX_W'(8'h03);
            BITS_4:  return IDX_W'(8'h0F);
            default: return {IDX_W{1'b1}};
        endcase
    endfunction

    // fixed colour table computed from the index
    function automatic ycc_t fixed_colour(input logic [IDX_W-1:0] i);
        ycc_t c;
        c[2] = COMP_W'(i);
        c[1] = COMP_W'(~i);
        c[0] = COMP_W'({i[3:0], i[7:4]});
        return c;
    endfunction

    // overlay weight in eighths: top code is fully opaque
    function automatic logic [WT_W-1:0] code_weight(input logic [CODE_W-1:0] c);
        return (c == '1) ? WT_W'(8) : WT_W'(c);
    endfunction

endpackage

// File: rtl/osd_palette_ram.sv
// Module: writable colour table, one write port and one registered read port.
// Assumes a read and a write to the same address in one cycle return the
// previous contents; every entry clears to zero under reset.
module osd_palette_ram #(
    parameter int IDX_W   = 8,
    parameter int ENTRY_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [ENTRY_W-1:0] wr_data,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic [ENTRY_W-1:0] rd_data
);

    localparam int DEPTH = 1 << IDX_W;

    logic [ENTRY_W-1:0] mem [DEPTH];

    // storage: clear on reset, otherwise take the write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // read register: samples the array before this edge's write lands
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else        rd_data <= mem[rd_addr];
    end

    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> mem[$past(wr_addr)] == $past(wr_data));

    assert_read_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_addr == wr_addr) |=> rd_data == $past(mem[rd_addr]));

endmodule

// File: rtl/osd_mix_lane.sv
// Module: one colour component of the blend, registered output.
// Assumes weight is in eighths, 0..8; rounds to nearest by adding half.
module osd_mix_lane #(
    parameter int COMP_W = 8,
    parameter int WT_W   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WT_W-1:0]   weight,
    input  logic [COMP_W-1:0] ovl,
    input  logic [COMP_W-1:0] vid,
    output logic [COMP_W-1:0] mix
);

    localparam int SHIFT = WT_W - 1;
    localparam int FULL  = 1 << SHIFT;
    localparam int SUM_W = COMP_W + WT_W;

    logic [SUM_W-1:0] sum;
    logic [WT_W-1:0]  vid_wt;

    // weighted sum with rounding term
    always_comb begin
        vid_wt = WT_W'(FULL) - weight;
        sum    = SUM_W'(ovl) * SUM_W'(weight)
               + SUM_W'(vid) * SUM_W'(vid_wt)
               + SUM_W'(FULL / 2);
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) mix <= '0;
        else        mix <= COMP_W'(sum >> SHIFT);
    end

    assert_weight_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        weight <= WT_W'(FULL));

    assert_opaque_R8: assert property (@(posedge clk) disable iff (!rst_n)
        weight == WT_W'(FULL) |=> mix == $past(ovl));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        weight == '0 |=> mix == $past(vid));

    assert_between_R7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((mix >= $past(ovl) || mix >= $past(vid)) &&
                  (mix <= $past(ovl) || mix <= $past(vid))));

endmodule

// File: rtl/osd_pixel_blender.sv
// Module: top of the overlay-over-video blender.
// Stage 1 masks the index, resolves the transparency key and weight, and reads
// the colour tables; stage 2 mixes the three components. Latency two cycles.
// Assumes the overlay and video pixels on the inputs are already aligned.
module osd_pixel_blender
    import osd_blend_pkg::*;
#(
    parameter int NUM_WIN = 2,
    parameter int WIN_W   = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pal_ycb_we,
    input  logic [2*COMP_W-1:0]      pal_ycb_data,
    input  logic                     pal_cr_we,
    input  logic [COMP_W+IDX_W-1:0]  pal_cr_data,
    input  logic [DEPTH_W*NUM_WIN-1:0] cfg_depth,
    input  logic [NUM_WIN-1:0]       cfg_fixed,
    input  logic [CODE_W*NUM_WIN-1:0] cfg_blend,
    input  logic [NUM_WIN-1:0]       cfg_key_en,
    input  logic [IDX_W*NUM_WIN-1:0] cfg_key,
    input  logic                     in_valid,
    input  logic [WIN_W-1:0]         in_win,
    input  logic [IDX_W-1:0]         in_idx,
    input  logic [COMP_W-1:0]        in_y,
    input  logic [COMP_W-1:0]        in_cb,
    input  logic [COMP_W-1:0]        in_cr,
    output logic                     out_valid,
    output logic [COMP_W-1:0]        out_y,
    output logic [COMP_W-1:0]        out_cb,
    output logic [COMP_W-1:0]        out_cr
);

    // ---------------- table write path ----------------
    logic [2*COMP_W-1:0] ycb_hold;
    logic [ENTRY_W-1:0]  wr_entry;
    logic [IDX_W-1:0]    wr_addr;

    // hold register for the Y/Cb half of an entry
    always_ff @(posedge clk) begin
        if (!rst_n)          ycb_hold <= '0;
        else if (pal_ycb_we) ycb_hold <= pal_ycb_data;
    end

    // assemble the entry committed by the Cr strobe
    always_comb begin
        wr_addr  = pal_cr_data[IDX_W-1:0];
        wr_entry = {ycb_hold, pal_cr_data[COMP_W+IDX_W-1:IDX_W]};
    end

    // ---------------- stage 0: per-window decode ----------------
    logic [DEPTH_W-1:0] win_depth;
    logic [CODE_W-1:0]  win_code;
    logic [IDX_W-1:0]   win_key;
    logic               win_key_en;
    logic               win_fixed;
    logic [IDX_W-1:0]   mask;
    logic [IDX_W-1:0]   idx_m;
    logic               key_hit;
    logic [WT_W-1:0]    weight0;

    // pick the configuration slice of the pixel's window
    always_comb begin
        win_depth  = '0;
        win_code   = '0;
        win_key    = '0;
        win_key_en = 1'b0;
        win_fixed  = 1'b0;
        for (int w = 0; w < NUM_WIN; w++) begin
            if (in_win == WIN_W'(w)) begin
                win_depth  = cfg_depth[w*DEPTH_W +: DEPTH_W];
                win_code   = cfg_blend[w*CODE_W +: CODE_W];
                win_key    = cfg_key[w*IDX_W +: IDX_W];
                win_key_en = cfg_key_en[w];
                win_fixed  = cfg_fixed[w];
            end
        end
    end

    // mask the index, test the key and derive the overlay weight
    always_comb begin
        mask    = index_mask(win_depth);
        idx_m   = in_idx & mask;
        key_hit = win_key_en && (idx_m == (win_key & mask));
        weight0 = key_hit ? '0 : code_weight(win_code);
    end

    // ---------------- stage 1: table read ----------------
    logic [ENTRY_W-1:0] ram_rd;
    logic               s1_valid;
    logic               s1_fixed;
    ycc_t               s1_fixcol;
    logic [WT_W-1:0]    s1_weight;
    ycc_t               s1_vid;
    ycc_t               s1_ovl;

    osd_palette_ram #(
        .IDX_W   (IDX_W),
        .ENTRY_W (ENTRY_W)
    ) u_palette (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (pal_cr_we),
        .wr_addr (wr_addr),
        .wr_data (wr_entry),
        .rd_addr (idx_m),
        .rd_data (ram_rd)
    );

    // stage 1 registers alongside the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_fixed  <= 1'b0;
            s1_fixcol <= '0;
            s1_weight <= '0;
            s1_vid    <= '0;
        end else begin
            s1_valid  <= in_valid;
            s1_fixed  <= win_fixed;
            s1_fixcol <= fixed_colour(idx_m);
            s1_weight <= weight0;
            s1_vid    <= {in_y, in_cb, in_cr};
        end
    end

    // choose between the writable and the fixed table
    always_comb begin
        s1_ovl = s1_fixed ? s1_fixcol : ycc_t'(ram_rd);
    end

    // ---------------- stage 2: component mix ----------------
    ycc_t mixed;

    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        osd_mix_lane #(
            .COMP_W (COMP_W),
            .WT_W   (WT_W)
        ) u_lane (
            .clk    (clk),
            .rst_n  (rst_n),
            .weight (s1_weight),
            .ovl    (s1_ovl[c]),
            .vid    (s1_vid[c]),
            .mix    (mixed[c])
        );
    end

    // output valid register
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= s1_valid;
    end

    // unpack components onto the ports
    always_comb begin
        out_y  = mixed[2];
        out_cb = mixed[1];
        out_cr = mixed[0];
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> out_valid == $past(in_valid, 2));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!out_valid && out_y == '0 && out_cb == '0 && out_cr == '0));

endmodule

// File: tb/test_osd_pixel_blender.sv
// Bench: behavioural reference model compared with the outputs every cycle.
module test_osd_pixel_blender;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pal_ycb_we = 1'b0;
    logic [15:0] pal_ycb_data = '0;
    logic        pal_cr_we = 1'b0;
    logic [15:0] pal_cr_data = '0;
    logic [3:0]  cfg_depth = '0;
    logic [1:0]  cfg_fixed = '0;
    logic [5:0]  cfg_blend = '0;
    logic [1:0]  cfg_key_en = '0;
    logic [15:0] cfg_key = '0;
    logic        in_valid = 1'b0;
    logic [0:0]  in_win = '0;
    logic [7:0]  in_idx = '0;
    logic [7:0]  in_y = '0, in_cb = '0, in_cr = '0;
    logic        out_valid;
    logic [7:0]  out_y, out_cb, out_cr;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    osd_pixel_blender i_osd_pixel_blender (
        .clk(clk), .rst_n(rst_n),
        .pal_ycb_we(pal_ycb_we), .pal_ycb_data(pal_ycb_data),
        .pal_cr_we(pal_cr_we), .pal_cr_data(pal_cr_data),
        .cfg_depth(cfg_depth), .cfg_fixed(cfg_fixed), .cfg_blend(cfg_blend),
        .cfg_key_en(cfg_key_en), .cfg_key(cfg_key),
        .in_valid(in_valid), .in_win(in_win), .in_idx(in_idx),
        .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr),
        .out_valid(out_valid), .out_y(out_y), .out_cb(out_cb), .out_cr(out_cr)
    );

    // reference model state
    logic [7:0] m_y [256];
    logic [7:0] m_cb[256];
    logic [7:0] m_cr[256];
    logic [7:0] m_hold_y = '0, m_hold_cb = '0;

    logic        pend_v = 1'b0, e1_v = 1'b0, e2_v = 1'b0;
    logic [23:0] pend_c = '0, e1_c = '0, e2_c = '0;
    string       pend_t = "R2", e1_t = "R2", e2_t = "R2";
    bit          running = 1'b0;

    function automatic logic [7:0] mix8(input int o, input int v, input int w);
        return 8'((o * w + v * (8 - w) + 4) / 8);
    endfunction

    // expected two-stage delay line
    always @(posedge clk) begin
        if (!rst_n) begin
            e1_v <= 1'b0; e2_v <= 1'b0;
        end else begin
            e1_v <= pend_v; e1_c <= pend_c; e1_t <= pend_t;
            e2_v <= e1_v;   e2_c <= e1_c;   e2_t <= e1_t;
        end
    end

    // per-cycle comparison away from the active edge
    always @(negedge clk) begin
        if (running && rst_n) begin
            checks++;
            if (out_valid !== e2_v) begin
                errors++;
                $display("FAIL %s valid: actual %0b expected %0b", e2_t, out_valid, e2_v);
            end else if (e2_v && {out_y, out_cb, out_cr} !== e2_c) begin
                errors++;
                $display("FAIL %s pixel: actual %h expected %h", e2_t,
                         {out_y, out_cb, out_cr}, e2_c);
            end
        end
    end

    // one cycle of stimulus; expected value uses table contents before this edge's write
    task automatic step(input string tag, input bit v, input bit win, input logic [7:0] idx,
                        input logic [7:0] vy, input logic [7:0] vcb, input logic [7:0] vcr,
                        input bit ycb_we, input logic [15:0] ycb,
                        input bit cr_we, input logic [15:0] crd);
        int d, bits, mask, im, w, key;
        logic [7:0] oy, ocb, ocr;
        in_valid = v; in_win = win; in_idx = idx;
        in_y = vy; in_cb = vcb; in_cr = vcr;
        pal_ycb_we = ycb_we; pal_ycb_data = ycb;
        pal_cr_we = cr_we; pal_cr_data = crd;
        d    = int'(cfg_depth[win*2 +: 2]);
        bits = 1 << d;
        mask = (1 << bits) - 1;
        im   = int'(idx) & mask;
        key  = int'(cfg_key[win*8 +: 8]) & mask;
        w    = (cfg_blend[win*3 +: 3] == 3'd7) ? 8 : int'(cfg_blend[win*3 +: 3]);
        if (cfg_key_en[win] && im == key) w = 0;
        if (cfg_fixed[win]) begin
            oy = 8'(im); ocb = ~8'(im); ocr = {im[3:0], im[7:4]};
        end else begin
            oy = m_y[im]; ocb = m_cb[im]; ocr = m_cr[im];
        end
        pend_v = v;
        pend_t = tag;
        pend_c = {mix8(oy, vy, w), mix8(ocb, vcb, w), mix8(ocr, vcr, w)};
        if (cr_we) begin
            m_y[crd[7:0]] = m_hold_y; m_cb[crd[7:0]] = m_hold_cb; m_cr[crd[7:0]] = crd[15:8];
        end
        if (ycb_we) begin
            m_hold_y = ycb[15:8]; m_hold_cb = ycb[7:0];
        end
        @(negedge clk);
    endtask

    task automatic px(input string tag, input bit win, input logic [7:0] idx,
                      input logic [7:0] vy, input logic [7:0] vcb, input logic [7:0] vcr);
        step(tag, 1'b1, win, idx, vy, vcb, vcr, 1'b0, 16'h0, 1'b0, 16'h0);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step("R2", 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 16'h0, 1'b0, 16'h0);
    endtask

    task automatic wr_entry(input logic [7:0] a, input logic [7:0] y, input logic [7:0] cb,
                            input logic [7:0] cr);
        step("R4", 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, {y, cb}, 1'b0, 16'h0);
        step("R4", 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b0, 16'h0, 1'b1, {cr, a});
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) begin m_y[i] = '0; m_cb[i] = '0; m_cr[i] = '0; end
        repeat (3) @(negedge clk);
        // R1: quiet outputs under reset
        checks++;
        if (out_valid !== 1'b0 || {out_y, out_cb, out_cr} !== 24'h0) begin
            errors++;
            $display("FAIL R1 reset: actual %b/%h expected 0/000000", out_valid, {out_y, out_cb, out_cr});
        end
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;
        // R1: first cycle after reset still quiet (also checked by the compare loop)
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 post-reset valid: actual %b expected 0", out_valid);
        end

        // window 0: 8-bit, writable table, opaque
        cfg_depth = 4'b0011; cfg_blend = 6'o07;
        px("R12", 1'b0, 8'h05, 8'h40, 8'h50, 8'h60);
        px("R12", 1'b0, 8'hFF, 8'h11, 8'h22, 8'h33);
        idle(2);

        // R4: write several entries, read them opaque
        wr_entry(8'h05, 8'hA1, 8'hB2, 8'hC3);
        wr_entry(8'hFF, 8'h10, 8'h20, 8'h30);
        wr_entry(8'h01, 8'hEE, 8'h0E, 8'h7F);
        wr_entry(8'h03, 8'h33, 8'h44, 8'h55);
        wr_entry(8'h0F, 8'h9A, 8'h8B, 8'h7C);
        // R4: both strobes together, commit uses previously held half
        step("R4", 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 16'h6162, 1'b1, {8'h63, 8'h07});
        px("R4", 1'b0, 8'h05, 8'h00, 8'h00, 8'h00);
        px("R4", 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
        px("R8", 1'b0, 8'h01, 8'h80, 8'h80, 8'h80);
        px("R4", 1'b0, 8'h07, 8'h00, 8'h00, 8'h00);
        idle(1);

        // R7: sweep codes 0..6, R9 at code 0
        for (int c = 0; c < 7; c++) begin
            cfg_blend = {3'd7, 3'(c)};
            px(c == 0 ? "R9" : "R7", 1'b0, 8'h05, 8'h10, 8'hF0, 8'h7E);
            px("R7", 1'b0, 8'h01, 8'hFF, 8'h00, 8'h81);
        end
        idle(2);

        // R6: fixed table
        cfg_fixed = 2'b01; cfg_blend = 6'o07;
        px("R6", 1'b0, 8'h00, 8'h00, 8'h00, 8'h00);
        px("R6", 1'b0, 8'h3C, 8'h00, 8'h00, 8'h00);
        px("R6", 1'b0, 8'hA5, 8'h00, 8'h00, 8'h00);
        cfg_blend = 6'o04;
        px("R6", 1'b0, 8'hF1, 8'h20, 8'h40, 8'h60);
        cfg_fixed = 2'b00; cfg_blend = 6'o07;
        idle(1);

        // R3: depth masking of index 0xFF
        cfg_depth = 4'b0000; px("R3", 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
        cfg_depth = 4'b0001; px("R3", 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
        cfg_depth = 4'b0010; px("R3", 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
        cfg_depth = 4'b0011; px("R3", 1'b0, 8'hFF, 8'h00, 8'h00, 8'h00);
        idle(1);

        // R10: key match, mismatch, disabled, masked compare
        cfg_key = 16'h0005; cfg_key_en = 2'b01;
        px("R10", 1'b0, 8'h05, 8'h12, 8'h34, 8'h56);
        px("R10", 1'b0, 8'h01, 8'h12, 8'h34, 8'h56);
        cfg_key_en = 2'b00;
        px("R10", 1'b0, 8'h05, 8'h12, 8'h34, 8'h56);
        cfg_depth = 4'b0010; cfg_key = 16'h00A3; cfg_key_en = 2'b01;
        px("R10", 1'b0, 8'h53, 8'h9A, 8'hBC, 8'hDE);
        px("R10", 1'b0, 8'h5F, 8'h9A, 8'hBC, 8'hDE);
        cfg_key_en = 2'b00; cfg_depth = 4'b0011;
        idle(1);

        // R11: window 1 has its own depth, table, blend and key
        cfg_depth = 4'b0111; cfg_fixed = 2'b10; cfg_blend = {3'd3, 3'd7};
        cfg_key = 16'h0300; cfg_key_en = 2'b10;
        px("R11", 1'b0, 8'h05, 8'h20, 8'h30, 8'h40);
        px("R11", 1'b1, 8'h05, 8'h20, 8'h30, 8'h40);
        px("R11", 1'b0, 8'h07, 8'h20, 8'h30, 8'h40);
        px("R11", 1'b1, 8'hF3, 8'h20, 8'h30, 8'h40);
        px("R11", 1'b1, 8'h0E, 8'hFF, 8'h01, 8'h80);
        cfg_depth = 4'b0011; cfg_fixed = 2'b00; cfg_blend = 6'o07; cfg_key_en = 2'b00;
        idle(1);

        // R5: write and read of the same entry in one cycle, then the next cycle
        step("R5", 1'b0, 1'b0, 8'h0, 8'h0, 8'h0, 8'h0, 1'b1, 16'h5A6B, 1'b0, 16'h0);
        step("R5", 1'b1, 1'b0, 8'h05, 8'h00, 8'h00, 8'h00, 1'b0, 16'h0, 1'b1, {8'h7C, 8'h05});
        px("R5", 1'b0, 8'h05, 8'h00, 8'h00, 8'h00);
        idle(1);

        // R2: back-to-back burst, then gapped pixels
        cfg_blend = 6'o05;
        for (int i = 0; i < 8; i++) px("R2", 1'b0, 8'(i * 37), 8'(i * 29), 8'(255 - i * 13), 8'(i * 7));
        for (int i = 0; i < 6; i++) begin
            px("R2", 1'b0, 8'(i * 51 + 1), 8'(i * 40), 8'(i * 11), 8'(200 - i));
            idle(i % 3);
        end
        idle(4);

        running = 1'b0;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule